// File: doc/BRIEF.md
# PLL Power Sequencer

This block is the control state machine that powers a phase-locked loop up and down in a safe order. It can also power a second, slave PHY that is driven from the same loop. On a prepare request it turns on bias for the master and then for the slave, if one is present. Each bias step is followed by a settle wait. It then starts the loop and polls a lock indication at a fixed interval, up to a bounded number of polls.

On lock it raises a PLL-on status and opens the clock gates and reference buffers, master before slave. If no lock is seen in time, it raises a lock-fail flag, leaves every clock gated and waits for an unprepare request. On an unprepare request from the running state, it gates the master clock before it stops the loop, then tears down the master and then the slave. PLL-on is the last output to drop.

All waits are counted in system-clock cycles and set by parameters. A request that arrives while a sequence is running is held until the machine reaches a resting state. The slave-present input is sampled once, when a power-up begins.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, every output is low.
- R2: Power-up without a slave raises, in this order: master bias; then, no sooner than SETTLE_CYC cycles later, PLL start; then after lock, on consecutive cycles, PLL-on, master clock gate and master reference buffer. No slave output moves.
- R3: Power-up with a slave raises slave bias one settle wait after master bias, and PLL start one settle wait after slave bias. After PLL-on, the outputs rise in this order: master clock gate, slave clock gate, master reference buffer, slave reference buffer. PLL start never rises before every needed bias is on.
- R4: Lock is sampled only every POLL_CYC cycles after PLL start. PLL-on rises exactly k*POLL_CYC+1 cycles after PLL start, for some k of at least 1.
- R5: If lock is not seen at any of MAX_POLLS polls, lock-fail rises exactly MAX_POLLS*POLL_CYC+1 cycles after PLL start. PLL-on, the clock gates and the reference buffers stay low, and a lock that arrives later has no effect.
- R6: Power-down lowers, in this order: master clock gate, PLL start, master reference buffer, master bias. A settle wait of at least SETTLE_CYC cycles follows the master bias step.
- R7: With a slave, the slave outputs are lowered only after the master settle wait, in this order: slave clock gate, slave reference buffer, slave bias. Slave bias is followed by its own settle wait.
- R8: PLL-on falls last in a power-down, after every other output is low. No clock gate or reference buffer is ever on while PLL-on is low.
- R9: An unprepare request during power-up is acted on as soon as power-up completes. A prepare request during power-down is acted on as soon as power-down completes.
- R10: An unprepare request in the lock-failed state drives every output low in a single cycle.
- R11: These requests change no output: unprepare while idle, and prepare while running or lock-failed.
- R12: The slave-present input is sampled only when a power-up starts. Changing it later in that power-up, or during the following power-down, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prep_req | input | 1 | Power-up request pulse |
| unprep_req | input | 1 | Power-down request pulse |
| slave_en | input | 1 | A slave PHY is present |
| lock_in | input | 1 | Lock indication from the loop |
| m_bias_en | output | 1 | Master bias and system mux enable |
| s_bias_en | output | 1 | Slave bias and system mux enable |
| pll_start | output | 1 | Loop start control |
| m_gclk_en | output | 1 | Master global clock gate |
| s_gclk_en | output | 1 | Slave global clock gate |
| m_rbuf_en | output | 1 | Master reference buffer enable |
| s_rbuf_en | output | 1 | Slave reference buffer enable |
| pll_on | output | 1 | Loop is locked and clocks are delivered |
| lock_fail | output | 1 | Lock was not seen before the timeout |

## Verification
The assertions assume that the slave-present input is used only through its copy sampled at power-up. They also assume that requests are single pulses, which the stimulus always drives one cycle wide. Lock is raised either well before the last poll or only after the timeout has fired. This keeps every random run clearly on one side of the timeout, so its outcome is known in advance. The bench also flips slave-present right after each request, so that a design that reads the live input would produce a different order of events.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_UP_MSET,
    S_UP_SSET,
    S_UP_POLL,
    S_UP_MGCLK,
    S_UP_SGCLK,
    S_UP_MRBUF,
    S_UP_SRBUF,
    S_RUN,
    S_DN_STOP,
    S_DN_MRBUF,
    S_DN_MBIAS,
    S_DN_MSET,
    S_DN_SRBUF,
    S_DN_SBIAS,
    S_DN_SSET,
    S_FAIL
  } seq_state_t;

  typedef struct packed {
    logic lock_fail;
    logic pll_on;
    logic s_rbuf;
    logic m_rbuf;
    logic s_gclk;
    logic m_gclk;
    logic pll_start;
    logic s_bias;
    logic m_bias;
  } seq_out_t;

endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pps_settle_timer.sv
module pps_settle_timer #(
  parameter int CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          done_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CW'(CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done   <= done_n;
    end
  end

  AST_SETTLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/pps_lock_poller.sv
module pps_lock_poller #(
  parameter int INTERVAL  = 12500,
  parameter int MAX_POLLS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lock_in,
  output logic locked,
  output logic timeout
);

  localparam int ICW = $clog2(INTERVAL + 1);
  localparam int PCW = $clog2(MAX_POLLS + 1);

  logic [ICW-1:0] tick_q, tick_n;
  logic [PCW-1:0] polls_q, polls_n;
  logic           busy_q, busy_n;
  logic           locked_n, timeout_n;

  always_comb begin
    tick_n    = tick_q;
    polls_n   = polls_q;
    busy_n    = busy_q;
    locked_n  = 1'b0;
    timeout_n = 1'b0;
    if (start) begin
      busy_n  = 1'b1;
      tick_n  = ICW'(INTERVAL - 1);
      polls_n = '0;
    end else if (busy_q) begin
      if (tick_q == '0) begin
        if (lock_in) begin
          locked_n = 1'b1;
          busy_n   = 1'b0;
        end else if (polls_q == PCW'(MAX_POLLS - 1)) begin
          timeout_n = 1'b1;
          busy_n    = 1'b0;
        end else begin
          polls_n = polls_q + 1'b1;
          tick_n  = ICW'(INTERVAL - 1);
        end
      end else begin
        tick_n = tick_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      polls_q <= '0;
      busy_q  <= 1'b0;
      locked  <= 1'b0;
      timeout <= 1'b0;
    end else begin
      tick_q  <= tick_n;
      polls_q <= polls_n;
      busy_q  <= busy_n;
      locked  <= locked_n;
      timeout <= timeout_n;
    end
  end

  AST_POLL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && timeout)); // R5
  AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (polls_q < PCW'(MAX_POLLS))); // R5

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 32,
  parameter int POLL_CYC   = 12500,
  parameter int MAX_POLLS  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prep_req,
  input  logic unprep_req,
  input  logic slave_en,
  input  logic lock_in,
  output logic m_bias_en,
  output logic s_bias_en,
  output logic pll_start,
  output logic m_gclk_en,
  output logic s_gclk_en,
  output logic m_rbuf_en,
  output logic s_rbuf_en,
  output logic pll_on,
  output logic lock_fail
);

  logic       rst_s_n;
  seq_state_t st_q, st_n;
  seq_out_t   o_q, o_n;
  logic       slv_q, slv_n;
  logic       up_q, up_n, dn_q, dn_n;
  logic       up_eff, dn_eff;
  logic       t_go, t_done, p_go, p_lock, p_tmo;

  pps_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  pps_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_s_n), .start(t_go), .done(t_done)
  );

  pps_lock_poller #(.INTERVAL(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_s_n), .start(p_go), .lock_in(lock_in),
    .locked(p_lock), .timeout(p_tmo)
  );

  assign up_eff = up_q | prep_req;
  assign dn_eff = dn_q | unprep_req;

  always_comb begin
    st_n  = st_q;
    o_n   = o_q;
    slv_n = slv_q;
    up_n  = up_eff;
    dn_n  = dn_eff;
    t_go  = 1'b0;
    p_go  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        dn_n = 1'b0;
        if (up_eff) begin
          up_n       = 1'b0;
          slv_n      = slave_en;
          o_n.m_bias = 1'b1;
          t_go       = 1'b1;
          st_n       = S_UP_MSET;
        end
      end
      S_UP_MSET: begin
        if (t_done) begin
          if (slv_q) begin
            o_n.s_bias = 1'b1;
            t_go       = 1'b1;
            st_n       = S_UP_SSET;
          end else begin
            o_n.pll_start = 1'b1;
            p_go          = 1'b1;
            st_n          = S_UP_POLL;
          end
        end
      end
      S_UP_SSET: begin
        if (t_done) begin
          o_n.pll_start = 1'b1;
          p_go          = 1'b1;
          st_n          = S_UP_POLL;
        end
      end
      S_UP_POLL: begin
        if (p_lock) begin
          o_n.pll_on = 1'b1;
          st_n       = S_UP_MGCLK;
        end else if (p_tmo) begin
          o_n.lock_fail = 1'b1;
          st_n          = S_FAIL;
        end
      end
      S_UP_MGCLK: begin
        o_n.m_gclk = 1'b1;
        st_n       = slv_q ? S_UP_SGCLK : S_UP_MRBUF;
      end
      S_UP_SGCLK: begin
        o_n.s_gclk = 1'b1;
        st_n       = S_UP_MRBUF;
      end
      S_UP_MRBUF: begin
        o_n.m_rbuf = 1'b1;
        st_n       = slv_q ? S_UP_SRBUF : S_RUN;
      end
      S_UP_SRBUF: begin
        o_n.s_rbuf = 1'b1;
        st_n       = S_RUN;
      end
      S_RUN: begin
        up_n = 1'b0;
        if (dn_eff) begin
          dn_n       = 1'b0;
          o_n.m_gclk = 1'b0;
          st_n       = S_DN_STOP;
        end
      end
      S_DN_STOP: begin
        o_n.pll_start = 1'b0;
        st_n          = S_DN_MRBUF;
      end
      S_DN_MRBUF: begin
        o_n.m_rbuf = 1'b0;
        st_n       = S_DN_MBIAS;
      end
      S_DN_MBIAS: begin
        o_n.m_bias = 1'b0;
        t_go       = 1'b1;
        st_n       = S_DN_MSET;
      end
      S_DN_MSET: begin
        if (t_done) begin
          if (slv_q) begin
            o_n.s_gclk = 1'b0;
            st_n       = S_DN_SRBUF;
          end else begin
            o_n.pll_on = 1'b0;
            st_n       = S_IDLE;
          end
        end
      end
      S_DN_SRBUF: begin
        o_n.s_rbuf = 1'b0;
        st_n       = S_DN_SBIAS;
      end
      S_DN_SBIAS: begin
        o_n.s_bias = 1'b0;
        t_go       = 1'b1;
        st_n       = S_DN_SSET;
      end
      S_DN_SSET: begin
        if (t_done) begin
          o_n.pll_on = 1'b0;
          st_n       = S_IDLE;
        end
      end
      S_FAIL: begin
        up_n = 1'b0;
        if (dn_eff) begin
          dn_n = 1'b0;
          o_n  = '0;
          st_n = S_IDLE;
        end
      end
      default: begin
        o_n  = '0;
        st_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= S_IDLE;
      o_q   <= '0;
      slv_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      o_q   <= o_n;
      slv_q <= slv_n;
      up_q  <= up_n;
      dn_q  <= dn_n;
    end
  end

  assign m_bias_en = o_q.m_bias;
  assign s_bias_en = o_q.s_bias;
  assign pll_start = o_q.pll_start;
  assign m_gclk_en = o_q.m_gclk;
  assign s_gclk_en = o_q.s_gclk;
  assign m_rbuf_en = o_q.m_rbuf;
  assign s_rbuf_en = o_q.s_rbuf;
  assign pll_on    = o_q.pll_on;
  assign lock_fail = o_q.lock_fail;

  AST_CLOCKS_NEED_ON: assert property (@(posedge clk) disable iff (!rst_s_n)
    (o_q.m_gclk || o_q.s_gclk || o_q.m_rbuf || o_q.s_rbuf) |-> o_q.pll_on); // R8
  AST_START_AFTER_BIAS: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(o_q.pll_start) |-> (o_q.m_bias && (o_q.s_bias || !slv_q))); // R3
  AST_GATE_BEFORE_STOP: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(o_q.pll_start) |-> !o_q.m_gclk); // R6
  AST_FAIL_GATED: assert property (@(posedge clk) disable iff (!rst_s_n)
    o_q.lock_fail |-> !(o_q.pll_on || o_q.m_gclk || o_q.s_gclk || o_q.m_rbuf || o_q.s_rbuf)); // R5
  AST_MASTER_GCLK_FIRST: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(o_q.s_gclk) |-> o_q.m_gclk); // R3
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($countones(o_q ^ $past(o_q)) <= 1) || ($past(o_q.lock_fail) && !o_q.lock_fail)); // R10

endmodule

// File: tb/pll_pwr_seq_test.sv
module pll_pwr_seq_test;

  localparam int ST = 3;
  localparam int PI = 6;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst_n, prep_req, unprep_req, slave_en, lock_in;
  logic m_bias_en, s_bias_en, pll_start, m_gclk_en, s_gclk_en;
  logic m_rbuf_en, s_rbuf_en, pll_on, lock_fail;

  always #4 clk = ~clk;

  pll_pwr_seq #(.SETTLE_CYC(ST), .POLL_CYC(PI), .MAX_POLLS(MP)) uut (
    .clk(clk), .rst_n(rst_n), .prep_req(prep_req), .unprep_req(unprep_req),
    .slave_en(slave_en), .lock_in(lock_in), .m_bias_en(m_bias_en),
    .s_bias_en(s_bias_en), .pll_start(pll_start), .m_gclk_en(m_gclk_en),
    .s_gclk_en(s_gclk_en), .m_rbuf_en(m_rbuf_en), .s_rbuf_en(s_rbuf_en),
    .pll_on(pll_on), .lock_fail(lock_fail)
  );

  // event code = output index * 2 + new value
  wire [8:0] ov = {lock_fail, pll_on, s_rbuf_en, m_rbuf_en, s_gclk_en,
                   m_gclk_en, pll_start, s_bias_en, m_bias_en};

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [8:0] prev = '0;
  int logc [64];
  int logt [64];
  int nlog = 0;
  int expc [64];
  int nexp = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) prev = '0;
    else begin
      for (int i = 0; i < 9; i++) begin
        if (ov[i] != prev[i] && nlog < 64) begin
          logc[nlog] = i * 2 + int'(ov[i]);
          logt[nlog] = cyc;
          nlog = nlog + 1;
        end
      end
      prev = ov;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int c);
    if (nexp < 64) begin expc[nexp] = c; nexp = nexp + 1; end
  endtask

  task automatic exp_up(input bit s, input bit ok);
    push(1); if (s) push(3); push(5);
    if (ok) begin
      push(15); push(7); if (s) push(9); push(11); if (s) push(13);
    end else push(17);
  endtask

  task automatic exp_dn(input bit s);
    push(6); push(4); push(10); push(0);
    if (s) begin push(8); push(12); push(2); end
    push(14);
  endtask

  task automatic exp_clear(input bit s);
    push(0); if (s) push(2); push(4); push(16);
  endtask

  task automatic clr();
    nlog = 0; nexp = 0;
  endtask

  function automatic int find(input int code);
    for (int i = 0; i < nlog; i++) if (logc[i] == code) return i;
    return -1;
  endfunction

  task automatic cmp(input string req, input bit gaps);
    int bad;
    bad = -1;
    for (int i = 0; i < nexp; i++) if (bad < 0 && (i >= nlog || logc[i] != expc[i])) bad = i;
    if (nlog != nexp && bad < 0) bad = nexp;
    chk(bad < 0, req, (bad >= 0 && bad < nlog) ? logc[bad] : nlog,
        (bad >= 0 && bad < nexp) ? expc[bad] : nexp);
    if (gaps) begin
      for (int i = 0; i + 1 < nlog; i++) begin
        if (logc[i] < 4) begin
          int g;
          g = logt[i+1] - logt[i];
          chk(g >= ST && g <= ST + 1, "R6 R7 settle gap", g, ST + 1);
        end
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_prep();
    @(posedge clk); #1 prep_req = 1'b1;
    @(posedge clk); #1 prep_req = 1'b0;
  endtask

  task automatic pulse_unprep();
    @(posedge clk); #1 unprep_req = 1'b1;
    @(posedge clk); #1 unprep_req = 1'b0;
  endtask

  task automatic lock_after(input int d);
    int guard;
    guard = 0;
    while (!pll_start && guard < 200) begin @(negedge clk); guard++; end
    if (d >= 0) begin
      repeat (d) @(negedge clk);
      lock_in = 1'b1;
    end
  endtask

  task automatic run_up(input bit s, input int d);
    lock_in = 1'b0;
    slave_en = s;
    pulse_prep();
    slave_en = ~s; // R12: late change must not matter
    lock_after(d);
    idle(60);
  endtask

  task automatic check_poll(input bit ok);
    int a, b;
    a = find(5);
    b = find(ok ? 15 : 17);
    if (a < 0 || b < 0) chk(1'b0, ok ? "R4 lock event" : "R5 fail event", b, 1);
    else if (ok) chk((logt[b] - logt[a] - 1) % PI == 0 && (logt[b] - logt[a]) > PI,
                     "R4 lock at poll boundary", logt[b] - logt[a], PI + 1);
    else chk(logt[b] - logt[a] == MP * PI + 1, "R5 timeout delay",
             logt[b] - logt[a], MP * PI + 1);
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; prep_req = 1'b0; unprep_req = 1'b0; slave_en = 1'b0; lock_in = 1'b0;
    idle(5);
    chk(ov == 9'd0, "R1 outputs in reset", int'(ov), 0);
    rst_n = 1'b1;
    idle(5);
    chk(ov == 9'd0, "R1 outputs after reset", int'(ov), 0);

    // R11: unprepare while idle
    clr(); pulse_unprep(); idle(20);
    cmp("R11 unprepare in idle", 1'b0);

    // R2 directed, no slave, immediate lock
    clr(); run_up(1'b0, 0); exp_up(1'b0, 1'b1);
    cmp("R2 power-up order R12", 1'b1); check_poll(1'b1);
    clr(); pulse_prep(); idle(20);
    cmp("R11 prepare while running", 1'b0);
    clr(); slave_en = 1'b1; pulse_unprep(); idle(60); exp_dn(1'b0);
    cmp("R6 R8 power-down no slave R12", 1'b1);

    // R3 / R7 directed with slave
    clr(); run_up(1'b1, 2); exp_up(1'b1, 1'b1);
    cmp("R3 power-up with slave", 1'b1); check_poll(1'b1);
    clr(); slave_en = 1'b0; pulse_unprep(); idle(60); exp_dn(1'b1);
    cmp("R7 R8 power-down with slave", 1'b1);

    // R5 / R10 directed timeout, late lock ignored
    clr(); run_up(1'b1, MP * PI + 3); exp_up(1'b1, 1'b0);
    cmp("R5 timeout with late lock", 1'b1); check_poll(1'b0);
    clr(); pulse_prep(); idle(20);
    cmp("R11 prepare while failed", 1'b0);
    clr(); pulse_unprep(); idle(20); exp_clear(1'b1);
    cmp("R10 unprepare clears failure", 1'b0);
    lock_in = 1'b0;

    // R9 unprepare held during power-up
    clr(); lock_in = 1'b1; slave_en = 1'b1; pulse_prep(); idle(2); pulse_unprep(); idle(120);
    exp_up(1'b1, 1'b1); exp_dn(1'b1);
    cmp("R9 unprepare held through power-up", 1'b1);
    // R9 prepare held during power-down
    clr(); slave_en = 1'b0; pulse_prep(); idle(60);
    pulse_unprep(); idle(3); pulse_prep(); idle(120);
    exp_up(1'b0, 1'b1); exp_dn(1'b0); exp_up(1'b0, 1'b1);
    cmp("R9 prepare held through power-down", 1'b1);
    clr(); pulse_unprep(); idle(60); exp_dn(1'b0);
    cmp("R6 final power-down", 1'b1);
    lock_in = 1'b0;

    // constrained random mix
    for (int it = 0; it < 16; it++) begin
      bit s, ok;
      int d;
      s  = 1'($urandom % 2);
      ok = ($urandom % 4) != 0;
      d  = ok ? int'($urandom % ((MP - 1) * PI - 2)) : (($urandom % 2) ? -1 : MP * PI + 3);
      clr(); run_up(s, d); exp_up(s, ok);
      cmp("R2 R3 R12 random power-up", 1'b1); check_poll(ok);
      if (ok) begin
        clr(); slave_en = ~s; pulse_unprep(); idle(60); exp_dn(s);
        cmp("R6 R7 R8 random power-down", 1'b1);
      end else begin
        clr(); pulse_unprep(); idle(20); exp_clear(s);
        cmp("R10 random failure clear", 1'b0);
      end
      lock_in = 1'b0;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared = compared + 1;
      mismatched = mismatched + 1;
      $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule